// File: doc/BRIEF.md
# Program Counter and Next-Address Selection Unit

This unit keeps the program counter of a single-cycle processor. It also returns, in the same cycle, the instruction word stored at that address in a small internal instruction store. At every rising clock edge the counter takes one of three next addresses. The first is the sequential address, the current value plus four. The second is a PC-relative branch target, taken when the decoder's branch request and the datapath's equality result are both high. The third is a region-relative absolute jump target, taken whenever the jump request is high.

The instruction word is driven straight out of the store so the decoder can use it in the same cycle. Its low 16 bits give the branch displacement in words. Its low 26 bits give the jump word address. A write port lets a test environment fill the instruction store before the program runs. The store can be written while reset is held.

Top module: `fetch_npc_unit`

## Requirements
- R1: A clock edge with `rst` high sets `pc` to 0x00000000.
- R2: `instr` always equals the word last written to store index `pc[IDX_W+1:2]`, with no clock delay; `IDX_W` defaults to 6 (64 words).
- R3: With `jmp` low and not both `br_req` and `eq_flag` high, the next `pc` is `pc + 4`.
- R4: With `br_req` and `eq_flag` high and `jmp` low, the next `pc` is `pc + 4 + (sign-extended instr[15:0] shifted left by 2)`.
- R5: A branch request with `eq_flag` low, or `eq_flag` high without a branch request, moves `pc` by 4 only.
- R6: With `jmp` high, the next `pc` is `{pc[31:28], instr[25:0], 2'b00}`.
- R7: When `jmp` and a taken branch (`br_req` and `eq_flag` high) occur in the same cycle, the jump target is used.
- R8: A negative displacement moves `pc` backward, wrapping modulo 2^32 below address 0.
- R9: A store write happens at a rising edge only when `ld_en` is high; with `ld_en` low, `ld_addr` and `ld_data` have no effect on the stored words.
- R10: The four upper bits of a jump target come from the current `pc`, not from `pc + 4`; this matters when `pc` is 0xFFFFFFFC.
- R11: `pc[1:0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| br_req | input | 1 | Decoder flag: the current instruction is a conditional branch |
| eq_flag | input | 1 | Datapath flag: the two compared registers are equal |
| jmp | input | 1 | Decoder flag: the current instruction is an absolute jump |
| ld_en | input | 1 | Write enable of the instruction store loading port |
| ld_addr | input | IDX_W (6) | Word index written by the loading port |
| ld_data | input | 32 | Word written by the loading port |
| instr | output | 32 | Instruction word at the current program counter |
| pc | output | 32 | Current program counter |

## Verification
A wrong selection or a wrong target sum shows on `pc` at the next clock edge. The bench walks a program through every path and compares the address after each edge. A corrupted counter or store index also shows at once on `instr` in the same cycle. It then misroutes every following step, because each later target is read from the wrong word. The wrap path through 0xFFFFFFFC tells apart a jump whose region bits come from the current address from one that takes them from the incremented address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Source chosen for the next program counter value
  typedef enum logic [1:0] {
    NPC_SEQ  = 2'd0,
    NPC_BRCH = 2'd1,
    NPC_JUMP = 2'd2
  } npc_src_e;

  // Architectural constants of the instruction word layout
  localparam int unsigned XLEN_DEF  = 32;
  localparam int unsigned IMM_W_DEF = 16;
  localparam int unsigned TGT_W_DEF = 26;

endpackage

// File: rtl/fetch_imem.sv
module fetch_imem #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  // Single write port, asynchronous read (distributed RAM style)
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/fetch_npc_calc.sv
module fetch_npc_calc
  import fetch_pkg::*;
#(
  parameter int unsigned XLEN  = XLEN_DEF,
  parameter int unsigned IMM_W = IMM_W_DEF,
  parameter int unsigned TGT_W = TGT_W_DEF
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [TGT_W-1:0] tgt_field,
  input  logic             br_req,
  input  logic             eq_flag,
  input  logic             jmp,
  output logic [XLEN-1:0]  npc
);

  localparam int unsigned IMM_PAD = XLEN - IMM_W - 2;
  localparam int unsigned REG_W   = XLEN - TGT_W - 2;

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  seq_addr;
  logic [XLEN-1:0]  br_off;
  logic [XLEN-1:0]  br_addr;
  logic [XLEN-1:0]  jmp_addr;
  logic [XLEN-1:0]  br_mux;
  logic             br_taken;
  npc_src_e         src;

  assign imm      = tgt_field[IMM_W-1:0];
  assign seq_addr = pc + XLEN'(4);
  assign br_off   = {{IMM_PAD{imm[IMM_W-1]}}, imm, 2'b00};
  assign br_addr  = seq_addr + br_off;
  // Region bits come from the current address
  assign jmp_addr = {pc[XLEN-1 -: REG_W], tgt_field, 2'b00};
  assign br_taken = br_req & eq_flag;

  always_comb begin
    if (jmp)           src = NPC_JUMP;
    else if (br_taken) src = NPC_BRCH;
    else               src = NPC_SEQ;
  end

  // First stage: sequential versus branch; second stage: jump override
  always_comb begin
    br_mux = (src == NPC_BRCH) ? br_addr : seq_addr;
    npc    = (src == NPC_JUMP) ? jmp_addr : br_mux;
  end

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int unsigned XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] pc
);

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= npc;
  end

endmodule

// File: rtl/fetch_npc_unit.sv
module fetch_npc_unit
  import fetch_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned XLEN  = XLEN_DEF,
  parameter int unsigned IMM_W = IMM_W_DEF,
  parameter int unsigned TGT_W = TGT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_req,
  input  logic             eq_flag,
  input  logic             jmp,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  output logic [XLEN-1:0]  instr,
  output logic [XLEN-1:0]  pc
);

  logic [XLEN-1:0]  npc;
  logic [IDX_W-1:0] rd_idx;

  assign rd_idx = pc[IDX_W+1:2];

  fetch_imem #(
    .IDX_W (IDX_W),
    .WORD_W(XLEN)
  ) imem_i (
    .clk  (clk),
    .we   (ld_en),
    .waddr(ld_addr),
    .wdata(ld_data),
    .raddr(rd_idx),
    .rdata(instr)
  );

  fetch_npc_calc #(
    .XLEN (XLEN),
    .IMM_W(IMM_W),
    .TGT_W(TGT_W)
  ) calc_i (
    .pc       (pc),
    .tgt_field(instr[TGT_W-1:0]),
    .br_req   (br_req),
    .eq_flag  (eq_flag),
    .jmp      (jmp),
    .npc      (npc)
  );

  fetch_pc_reg #(
    .XLEN(XLEN)
  ) pcr_i (
    .clk(clk),
    .rst(rst),
    .npc(npc),
    .pc (pc)
  );

endmodule

// File: rtl/fetch_npc_chk.sv
module fetch_npc_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            br_req,
  input logic            eq_flag,
  input logic            jmp,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] pc
);

  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> pc == '0);

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !(br_req && eq_flag)) |=> pc == $past(pc) + XLEN'(4));

  assert_branch_tgt_R4: assert property (@(posedge clk) disable iff (rst)
    (br_req && eq_flag && !jmp) |=>
      pc == $past(pc) + XLEN'(4) +
            {{(XLEN-18){$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  assert_jump_tgt_R6: assert property (@(posedge clk) disable iff (rst)
    jmp |=> pc == {$past(pc[XLEN-1:28]), $past(instr[25:0]), 2'b00});

  assert_aligned_R11: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

endmodule

bind fetch_npc_unit fetch_npc_chk #(.XLEN(XLEN)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .br_req (br_req),
  .eq_flag(eq_flag),
  .jmp    (jmp),
  .instr  (instr),
  .pc     (pc)
);

// File: tb/fetch_npc_unit_tb_top.sv
module fetch_npc_unit_tb_top;

  localparam int IDX_W = 6;
  localparam int DEPTH = 1 << IDX_W;
  localparam int NSTEP = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             br_req = 1'b0;
  logic             eq_flag = 1'b0;
  logic             jmp = 1'b0;
  logic             ld_en = 1'b0;
  logic [IDX_W-1:0] ld_addr = '0;
  logic [31:0]      ld_data = '0;
  logic [31:0]      instr;
  logic [31:0]      pc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] prog [DEPTH];

  // {br_req, eq_flag, jmp, expected pc after the edge}
  localparam logic [34:0] VEC [NSTEP] = '{
    {3'b000, 32'h0000_0004},  // R3 sequential
    {3'b110, 32'h0000_0014},  // R4 taken forward (+3 words)
    {3'b100, 32'h0000_0018},  // R5 branch not equal
    {3'b010, 32'h0000_001C},  // R5 equal without branch
    {3'b110, 32'h0000_000C},  // R8 backward (-5 words)
    {3'b111, 32'h0C00_0020},  // R7 jump beats taken branch
    {3'b001, 32'h0000_0008},  // R6 plain jump
    {3'b110, 32'h0000_0000},  // R8 back to zero
    {3'b001, 32'h0000_0010},  // R6 jump
    {3'b110, 32'hFFFF_FFFC},  // R8 wrap below zero
    {3'b001, 32'hF000_0004},  // R10 region from current pc
    {3'b000, 32'hF000_0008}   // R3 sequential in high region
  };

  fetch_npc_unit #(.IDX_W(IDX_W)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .br_req (br_req),
    .eq_flag(eq_flag),
    .jmp    (jmp),
    .ld_en  (ld_en),
    .ld_addr(ld_addr),
    .ld_data(ld_data),
    .instr  (instr),
    .pc     (pc)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_pc;
    for (int k = 0; k < DEPTH; k++) prog[k] = 32'h0000_0000;
    prog[0]  = 32'h0000_0004;
    prog[1]  = 32'h0000_0003;
    prog[2]  = 32'h0000_FFFD;
    prog[3]  = 32'h0300_0008;
    prog[4]  = 32'h0000_FFFA;
    prog[5]  = 32'h0000_0010;
    prog[6]  = 32'h0000_FFFC;
    prog[7]  = 32'h0000_FFFB;
    prog[8]  = 32'h0000_0002;
    prog[63] = 32'h0000_0001;

    // Fill the store while reset holds the counter
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      ld_en   = 1'b1;
      ld_addr = IDX_W'(k);
      ld_data = prog[k];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    check(pc == 32'h0, "R1 reset value", pc, 32'h0);
    check(instr == prog[0], "R2 word at reset address", instr, prog[0]);

    rst = 1'b0;
    exp_pc = 32'h0;
    for (int i = 0; i < NSTEP; i++) begin
      check(instr == prog[exp_pc[IDX_W+1:2]], "R2 instruction at pc",
            instr, prog[exp_pc[IDX_W+1:2]]);
      {br_req, eq_flag, jmp} = VEC[i][34:32];
      @(negedge clk);
      exp_pc = VEC[i][31:0];
      check(pc == exp_pc, "R3/R4/R5/R6/R7/R8/R10 next pc", pc, exp_pc);
      check(pc[1:0] == 2'b00, "R11 alignment", {30'h0, pc[1:0]}, 32'h0);
    end
    {br_req, eq_flag, jmp} = 3'b000;

    // R1: reset from a high address
    rst = 1'b1;
    @(negedge clk);
    check(pc == 32'h0, "R1 reset from running state", pc, 32'h0);

    // R9: disabled write leaves the store alone
    ld_en   = 1'b0;
    ld_addr = '0;
    ld_data = 32'hDEAD_BEEF;
    @(negedge clk);
    check(instr == prog[0], "R9 write ignored without enable", instr, prog[0]);
    ld_en   = 1'b1;
    ld_data = 32'h1234_5678;
    @(negedge clk);
    ld_en = 1'b0;
    check(instr == 32'h1234_5678, "R9 enabled write visible", instr, 32'h1234_5678);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule